// File: doc/BRIEF.md
# Bounded-Noise Triangle Wave Generator

This block produces two sample streams from one clock. The first is a clean triangle wave. Its level climbs by one unit up to a configurable peak, falls by one unit down to zero, and then starts climbing again from one. Each level is held for a fixed number of samples before it moves.

The second stream is a noisy copy of the clean wave. A pseudo-random offset of minus one, zero or plus one is added to each sample. The offset comes from an internal linear-feedback shift register. A limiter keeps the noisy sample within one unit of the clean sample and within one unit of the previous noisy sample. When the raw offset would break either bound, the limiter moves the noisy sample to the clean level, or one unit toward it.

The block is a free-running source for stimulus or test-signal generation. It has no back-pressure. The single enable input advances both streams by one sample per clock. While enable is low, every piece of internal state holds still, so a consumer that cannot take a sample simply drops enable.

Top module: `bounded_noise_tri_gen`

## Requirements
- R1: While reset is high at a clock edge, the block loads clean sample 1, noisy sample 1 and a rising direction. The noise register is loaded with the SEED parameter at the same edge.
- R2: On each enabled edge, the clean sample moves by at most one unit. Each clean level is output for exactly HOLD consecutive enabled samples (default 5) before it steps.
- R3: While rising, a step away from level PEAK (default 30766) goes to PEAK-1 and switches the direction to falling. The clean sample never exceeds PEAK.
- R4: While falling, each step lowers the level by one, down to 0. A step away from level 0 goes to 1 and switches the direction to rising.
- R5: At every sample, the noisy value differs from the clean value by at most one unit.
- R6: Across every enabled edge, the noisy value changes by at most one unit.
- R7: The raw offset comes from the two low bits of a 16-bit register. The code maps to an offset as follows: code 0 gives -1, code 1 gives 0, code 2 gives +1 and code 3 gives 0. The offset is read from the register value before the edge and is applied to the clean value that the same edge produces. On every enabled edge, the register shifts right by one and is XORed with 16'hB400 when the bit shifted out is 1.
- R8: Let the candidate be the new clean value plus the offset. If the candidate lies more than one unit from the previous noisy value, the new noisy value is the previous noisy value moved one unit toward the new clean value. This equals the clean value whenever that is adjacent. Otherwise the new noisy value is the candidate.
- R9: When the new clean value is 0, an offset of -1 is treated as 0, so the noisy value never wraps below zero.
- R10: While enable is low, both outputs, the hold count, the direction and the noise register all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance both streams by one sample on this edge |
| clean_o | output | WIDTH (16) | Clean triangle sample |
| noisy_o | output | WIDTH (16) | Noisy sample, bounded against clean and against its own previous value |

## Verification
The bench builds the generator with PEAK=6 and HOLD=3, which gives a full wave period of 36 enabled samples. With these values, the peak turn-around, the restart from zero and the floor on the negative offset all occur many times within a few hundred cycles. At the default peak, a single period would take about 300,000 samples. The bench mirrors the stated noise register and mapping, so each noisy sample is predicted exactly. This covers clamping while the wave is holding, while it is stepping, and around enable gaps and a reset in mid-ramp.

// File: rtl/bnt_pkg.sv
package bnt_pkg;

  typedef enum logic [1:0] {
    OFS_DOWN = 2'd0,
    OFS_NONE = 2'd1,
    OFS_UP   = 2'd2
  } noise_ofs_e;

  typedef enum logic {
    RAMP_RISE = 1'b0,
    RAMP_FALL = 1'b1
  } ramp_dir_e;

  // Two random bits -> offset; the spare code folds onto "none".
  function automatic noise_ofs_e decode_ofs(input logic [1:0] code);
    case (code)
      2'd0:    return OFS_DOWN;
      2'd2:    return OFS_UP;
      default: return OFS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bnt_ramp_seq.sv
module bnt_ramp_seq
  import bnt_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PEAK  = 30766,
  parameter int HOLD  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] level_nxt_o
);

  localparam logic [WIDTH-1:0] PEAK_V = WIDTH'(PEAK);
  localparam logic [WIDTH-1:0] ONE_V  = WIDTH'(1);

  logic [WIDTH-1:0] level_q;
  ramp_dir_e        dir_q;
  logic [WIDTH-1:0] level_step;
  ramp_dir_e        dir_step;
  logic             step_now;

  // Hold stage: a counter only when levels are held more than one sample.
  generate
    if (HOLD <= 1) begin : g_no_hold
      assign step_now = 1'b1;
    end else begin : g_hold
      localparam int HW = $clog2(HOLD);
      localparam logic [HW-1:0] LAST = HW'(HOLD - 1);
      logic [HW-1:0] hold_q;

      assign step_now = (hold_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          hold_q <= '0;
        end else if (en) begin
          hold_q <= step_now ? '0 : hold_q + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    level_step = level_q;
    dir_step   = dir_q;
    if (dir_q == RAMP_RISE) begin
      if (level_q == PEAK_V) begin
        level_step = level_q - ONE_V;
        dir_step   = RAMP_FALL;
      end else begin
        level_step = level_q + ONE_V;
      end
    end else begin
      if (level_q == '0) begin
        level_step = ONE_V;
        dir_step   = RAMP_RISE;
      end else begin
        level_step = level_q - ONE_V;
      end
    end
  end

  assign level_nxt_o = step_now ? level_step : level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= ONE_V;
      dir_q   <= RAMP_RISE;
    end else if (en) begin
      level_q <= level_nxt_o;
      if (step_now) dir_q <= dir_step;
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/bnt_noise_src.sv
module bnt_noise_src
  import bnt_pkg::*;
#(
  parameter int          LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output noise_ofs_e ofs_o
);

  logic [LW-1:0] state_q;
  logic [LW-1:0] state_nxt;

  always_comb begin
    state_nxt = {1'b0, state_q[LW-1:1]};
    if (state_q[0]) state_nxt = state_nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (en) begin
      state_q <= state_nxt;
    end
  end

  assign ofs_o = decode_ofs(state_q[1:0]);

endmodule

// File: rtl/bnt_limiter.sv
module bnt_limiter
  import bnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] clean_nxt_i,
  input  logic [WIDTH-1:0] noisy_cur_i,
  input  noise_ofs_e       ofs_i,
  output logic [WIDTH-1:0] noisy_nxt_o
);

  localparam logic [WIDTH:0] ONE_W = (WIDTH+1)'(1);

  logic [WIDTH:0] cand_w;
  logic [WIDTH:0] cur_w;
  logic           too_high;
  logic           too_low;

  // Candidate with floor/ceiling so the sum never wraps.
  always_comb begin
    cand_w = {1'b0, clean_nxt_i};
    case (ofs_i)
      OFS_DOWN: if (clean_nxt_i != '0) cand_w = {1'b0, clean_nxt_i} - ONE_W;
      OFS_UP:   if (clean_nxt_i != '1) cand_w = {1'b0, clean_nxt_i} + ONE_W;
      default:  cand_w = {1'b0, clean_nxt_i};
    endcase
  end

  assign cur_w    = {1'b0, noisy_cur_i};
  assign too_high = cand_w > (cur_w + ONE_W);
  assign too_low  = (cand_w + ONE_W) < cur_w;

  // A rejected candidate lies on the same side as the clean value,
  // so one unit from the old sample is also one unit toward clean.
  always_comb begin
    if (too_high) begin
      noisy_nxt_o = noisy_cur_i + WIDTH'(1);
    end else if (too_low) begin
      noisy_nxt_o = noisy_cur_i - WIDTH'(1);
    end else begin
      noisy_nxt_o = cand_w[WIDTH-1:0];
    end
  end

endmodule

// File: rtl/bounded_noise_tri_gen.sv
module bounded_noise_tri_gen
  import bnt_pkg::*;
#(
  parameter int          WIDTH = 16,
  parameter int          PEAK  = 30766,
  parameter int          HOLD  = 5,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter logic [15:0] TAPS  = 16'hB400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] clean_o,
  output logic [WIDTH-1:0] noisy_o
);

  localparam int NOISE_W = 16;

  logic [WIDTH-1:0] clean_q;
  logic [WIDTH-1:0] clean_nxt;
  logic [WIDTH-1:0] noisy_q;
  logic [WIDTH-1:0] noisy_nxt;
  noise_ofs_e       ofs;

  bnt_ramp_seq #(
    .WIDTH(WIDTH),
    .PEAK (PEAK),
    .HOLD (HOLD)
  ) u_ramp (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .level_o    (clean_q),
    .level_nxt_o(clean_nxt)
  );

  bnt_noise_src #(
    .LW  (NOISE_W),
    .TAPS(TAPS),
    .SEED(SEED)
  ) u_noise (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .ofs_o(ofs)
  );

  bnt_limiter #(
    .WIDTH(WIDTH)
  ) u_limit (
    .clean_nxt_i(clean_nxt),
    .noisy_cur_i(noisy_q),
    .ofs_i      (ofs),
    .noisy_nxt_o(noisy_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      noisy_q <= WIDTH'(1);
    end else if (en) begin
      noisy_q <= noisy_nxt;
    end
  end

  assign clean_o = clean_q;
  assign noisy_o = noisy_q;

endmodule

// File: rtl/bounded_noise_tri_gen_chk.sv
module bounded_noise_tri_gen_chk #(
  parameter int WIDTH = 16,
  parameter int PEAK  = 30766
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] clean,
  input logic [WIDTH-1:0] noisy
);

  function automatic logic within1(input logic [WIDTH-1:0] a,
                                   input logic [WIDTH-1:0] b);
    logic [WIDTH:0] aw;
    logic [WIDTH:0] bw;
    aw = {1'b0, a};
    bw = {1'b0, b};
    return (aw <= bw + 1'b1) && (bw <= aw + 1'b1);
  endfunction

  logic rst_seen_q = 1'b0;

  always @(posedge clk) begin
    if (rst_seen_q && !rst) begin
      assert_reset_state_R1: assert (clean == WIDTH'(1) && noisy == WIDTH'(1))
        else $error("reset state wrong");
    end
    rst_seen_q <= rst;
  end

  assert_clean_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> within1(clean, $past(clean)));

  assert_peak_bound_R3: assert property (@(posedge clk) disable iff (rst)
    clean <= WIDTH'(PEAK));

  assert_near_clean_R5: assert property (@(posedge clk) disable iff (rst)
    within1(noisy, clean));

  assert_noisy_step_R6: assert property (@(posedge clk) disable iff (rst)
    en |=> within1(noisy, $past(noisy)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(clean) && $stable(noisy)));

endmodule

bind bounded_noise_tri_gen bounded_noise_tri_gen_chk #(
  .WIDTH(WIDTH),
  .PEAK (PEAK)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .en   (en),
  .clean(clean_o),
  .noisy(noisy_o)
);

// File: tb/tb_bounded_noise_tri_gen.sv
`timescale 1ns/1ps
module tb_bounded_noise_tri_gen;

  localparam int          W  = 16;
  localparam int          PK = 6;
  localparam int          HD = 3;
  localparam logic [15:0] SD = 16'hACE1;
  localparam logic [15:0] TP = 16'hB400;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] clean;
  logic [W-1:0] noisy;

  always #4 clk = ~clk;

  bounded_noise_tri_gen #(
    .WIDTH(W), .PEAK(PK), .HOLD(HD), .SEED(SD), .TAPS(TP)
  ) dut (
    .clk(clk), .rst(rst), .en(en), .clean_o(clean), .noisy_o(noisy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int          m_lvl, m_hold, m_up, m_noisy, prev_noisy;
  logic [15:0] m_lfsr;
  int          clamp_hits = 0, floor_hits = 0, peak_hits = 0;
  int          seen_lo = 0, seen_mid = 0, seen_hi = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lvl = 1; m_hold = 0; m_up = 1; m_noisy = 1; m_lfsr = SD;
  endtask

  task automatic model_step();
    int ofs;
    int cand;
    ofs = (m_lfsr[1:0] == 2'd0) ? -1 : (m_lfsr[1:0] == 2'd2) ? 1 : 0;
    if (m_hold == HD - 1) begin
      m_hold = 0;
      if (m_up != 0) begin
        if (m_lvl == PK) begin m_lvl = PK - 1; m_up = 0; peak_hits++; end
        else m_lvl++;
      end else begin
        if (m_lvl == 0) begin m_lvl = 1; m_up = 1; end
        else m_lvl--;
      end
    end else begin
      m_hold++;
    end
    if (m_lvl == 0 && ofs < 0) begin ofs = 0; floor_hits++; end
    cand = m_lvl + ofs;
    if (cand - m_noisy > 1) begin m_noisy++; clamp_hits++; end
    else if (m_noisy - cand > 1) begin m_noisy--; clamp_hits++; end
    else m_noisy = cand;
    if (m_noisy - m_lvl < 0) seen_lo++;
    else if (m_noisy - m_lvl > 0) seen_hi++;
    else seen_mid++;
    m_lfsr = m_lfsr[0] ? ({1'b0, m_lfsr[15:1]} ^ TP) : {1'b0, m_lfsr[15:1]};
  endtask

  task automatic check_outputs(input string tag);
    int c, n, d;
    c = int'(clean);
    n = int'(noisy);
    chk(tag, c, m_lvl);
    chk("R7 R8 noisy value", n, m_noisy);
    d = n - c;
    chk("R5 noisy near clean", int'(d >= -1 && d <= 1), 1);
    d = n - prev_noisy;
    chk("R6 noisy step", int'(d >= -1 && d <= 1), 1);
    if (c == 0) chk("R9 no wrap at zero", int'(n <= 1), 1);
    prev_noisy = n;
  endtask

  // starts and ends just after a falling edge
  task automatic do_cycle(input logic e, input string tag);
    en = e;
    @(posedge clk);
    if (e) model_step();
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    prev_noisy = 1;
    chk("R1 reset clean", int'(clean), 1);
    chk("R1 reset noisy", int'(noisy), 1);
  endtask

  task automatic t_ramp_full();
    for (int i = 0; i < 80; i++) do_cycle(1'b1, "R2 R3 R4 clean ramp");
  endtask

  task automatic t_enable_gaps();
    int c0, n0;
    for (int i = 0; i < 30; i++) begin
      c0 = int'(clean); n0 = int'(noisy);
      do_cycle(1'b0, "R10 idle clean");
      chk("R10 idle holds clean", int'(clean), c0);
      chk("R10 idle holds noisy", int'(noisy), n0);
      do_cycle(1'b1, "R2 clean after gap");
      if (i % 3 == 0) do_cycle(1'b0, "R10 idle clean");
    end
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 7; i++) do_cycle(1'b1, "R2 clean pre-reset");
    t_reset();
    for (int i = 0; i < 12; i++) do_cycle(1'b1, "R2 R4 clean post-reset");
  endtask

  task automatic t_long_run();
    for (int i = 0; i < 200; i++) do_cycle(1'b1, "R3 R4 clean long run");
  endtask

  task automatic t_coverage();
    chk("R3 peak turn reached", int'(peak_hits > 0), 1);
    chk("R8 clamp exercised", int'(clamp_hits > 0), 1);
    chk("R9 floor exercised", int'(floor_hits > 0), 1);
    chk("R7 all offsets seen", int'(seen_lo > 0 && seen_mid > 0 && seen_hi > 0), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ramp_full();
    t_enable_gaps();
    t_mid_reset();
    t_long_run();
    t_coverage();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule